// File: doc/BRIEF.md
# Tomasulo Reservation Station Array

This block holds a small pool of reservation stations that feed one functional unit, together with a table that records, for every architectural register, its current value and the station (if any) that will next produce it. Instructions arrive in program order on the issue port. Each one is placed in the lowest-numbered idle station. A source operand whose register has no pending producer is copied in as a value. Otherwise the station keeps the producer's tag and waits. The destination register is then renamed to the issuing station, which replaces any older pending producer.

Results come back from the functional unit and are driven onto a registered common result bus as a (tag, value) pair. Every waiting station compares its missing operands against that tag and grabs the value on a match. Every register still tagged with that producer takes the value and becomes valid again. A station whose operands are both present can be sent to the functional unit. One station is dispatched per cycle, the lowest-numbered ready one first. It stays occupied until its own result appears on the bus. Because operands travel by tag, false dependences between registers vanish without any explicit renaming step.

Top module: `opsched_station_array`

## Requirements
- R1: Issue is accepted only while at least one station is idle. `iss_stall` is high exactly when every station is occupied, and an issue presented while `iss_stall` is high is ignored.
- R2: A register tag of 0 means the register value is current. Tag value k (1 to NUM_ST) means station k-1 will produce it. `disp_tag` and `cdb_tag` use the same encoding.
- R3: At issue, a source whose register tag is 0 is captured as a ready value. Otherwise the station stores that tag and waits.
- R4: At issue, the destination register's tag is set to the issuing station's ID, even when it already carried another tag. Later readers of that register therefore receive this instruction's result.
- R5: Each cycle, a waiting station compares its unready operand tags with the bus tag, and on a match it captures the bus value and marks that operand ready.
- R6: If an issuing source's register tag equals the tag on the bus in that same cycle, the station takes the bus value directly and the operand is ready.
- R7: A station is dispatched only when both of its operands are ready. If any station is ready, one is dispatched in the next cycle with its opcode, both operand values and its ID.
- R8: When several stations are ready, the lowest-index one is dispatched first.
- R9: A result reaches the bus one cycle after it arrives from the functional unit. At most one result is on the bus per cycle, and its tag always names a station that was dispatched. That station becomes idle in the cycle its result is broadcast.
- R10: A broadcast writes its value into each register whose tag equals the bus tag and clears that tag. A register renamed to a newer producer keeps its tag.
- R11: After reset every station is idle, no dispatch or broadcast is pending, every register tag is 0, and register r holds the value r.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W (2) | Opcode passed through to the functional unit |
| iss_srca | input | log2(NUM_REG) (3) | First source register |
| iss_srcb | input | log2(NUM_REG) (3) | Second source register |
| iss_dst | input | log2(NUM_REG) (3) | Destination register |
| iss_stall | output | 1 | All stations occupied; issue not accepted |
| disp_valid | output | 1 | Dispatch to the functional unit |
| disp_op | output | OP_W (2) | Dispatched opcode |
| disp_opa | output | DATA_W (16) | First operand value |
| disp_opb | output | DATA_W (16) | Second operand value |
| disp_tag | output | TAG_W (3) | ID of the dispatched station |
| fu_valid | input | 1 | Functional unit result valid |
| fu_tag | input | TAG_W (3) | Station ID of the result |
| fu_value | input | DATA_W (16) | Result value |
| cdb_valid | output | 1 | Result broadcast on the bus |
| cdb_tag | output | TAG_W (3) | Producer ID being broadcast |
| cdb_value | output | DATA_W (16) | Value being broadcast |

## Verification
Embedded assertions watch the following properties on every cycle:
- A station is allocated only while idle.
- A station is granted only with both operands ready.
- At most one station is granted.
- A station leaves occupancy only on its own broadcast.
- Each bus tag names an executing station.
- A register tag changes only on a rename or a matching broadcast.

Other behaviour can only be shown end to end by the bench's sweep over every source and destination combination. This covers correct operand values under renaming and overwritten tags, the same-cycle bypass, ordering among several ready stations, and the fact that a stalled issue leaves no trace. In that sweep, each dispatched operand and each broadcast value is compared against a sequential execution of the same program.

// File: rtl/opsched_pkg.sv
package opsched_pkg;
  typedef enum logic [1:0] {
    ST_FREE = 2'd0,
    ST_WAIT = 2'd1,
    ST_EXEC = 2'd2
  } st_e;
endpackage

// File: rtl/opsched_tag_table.sv
module opsched_tag_table #(
  parameter int NUM_REG = 8,
  parameter int DATA_W  = 16,
  parameter int TAG_W   = 3,
  localparam int RIW    = $clog2(NUM_REG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RIW-1:0]    rd_a_idx,
  input  logic [RIW-1:0]    rd_b_idx,
  output logic [TAG_W-1:0]  rd_a_tag,
  output logic [DATA_W-1:0] rd_a_val,
  output logic [TAG_W-1:0]  rd_b_tag,
  output logic [DATA_W-1:0] rd_b_val,
  input  logic              ren_en,
  input  logic [RIW-1:0]    ren_idx,
  input  logic [TAG_W-1:0]  ren_tag,
  input  logic              bus_v,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_val
);
  logic [DATA_W-1:0] val_q [NUM_REG];
  logic [TAG_W-1:0]  tag_q [NUM_REG];

  assign rd_a_tag = tag_q[rd_a_idx];
  assign rd_a_val = val_q[rd_a_idx];
  assign rd_b_tag = tag_q[rd_b_idx];
  assign rd_b_val = val_q[rd_b_idx];

  // Broadcast clears matching tags first; a same-cycle rename wins (R4, R10).
  always_ff @(posedge clk) begin
    for (int r = 0; r < NUM_REG; r++) begin
      if (rst) begin
        val_q[r] <= DATA_W'(r);
        tag_q[r] <= '0;
      end else begin
        if (bus_v && tag_q[r] != '0 && tag_q[r] == bus_tag) begin
          val_q[r] <= bus_val;
          tag_q[r] <= '0;
        end
        if (ren_en && ren_idx == RIW'(r)) tag_q[r] <= ren_tag;
      end
    end
  end

  for (genvar r = 0; r < NUM_REG; r++) begin : g_chk
    // R10: a pending tag survives unless renamed or matched by the bus.
    assert_tag_hold_R10: assert property (@(posedge clk) disable iff (rst)
      (tag_q[r] != '0 && !(ren_en && ren_idx == RIW'(r)) && !(bus_v && bus_tag == tag_q[r]))
      |=> $stable(tag_q[r]));
    // R10: matching broadcast without rename leaves the register valid with the bus value.
    assert_tag_clear_R10: assert property (@(posedge clk) disable iff (rst)
      (tag_q[r] != '0 && bus_v && bus_tag == tag_q[r] && !(ren_en && ren_idx == RIW'(r)))
      |=> (tag_q[r] == '0 && val_q[r] == $past(bus_val)));
  end
endmodule

// File: rtl/opsched_station.sv
module opsched_station
  import opsched_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 3,
  parameter int OP_W   = 2,
  parameter logic [TAG_W-1:0] ID = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              alloc,
  input  logic [OP_W-1:0]   in_op,
  input  logic              in_a_rdy,
  input  logic [TAG_W-1:0]  in_a_tag,
  input  logic [DATA_W-1:0] in_a_val,
  input  logic              in_b_rdy,
  input  logic [TAG_W-1:0]  in_b_tag,
  input  logic [DATA_W-1:0] in_b_val,
  input  logic              bus_v,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_val,
  input  logic              grant,
  output logic              busy,
  output logic              exec,
  output logic              ready,
  output logic [OP_W-1:0]   op,
  output logic [DATA_W-1:0] a_val,
  output logic [DATA_W-1:0] b_val
);
  st_e              st_q;
  logic             a_rdy_q, b_rdy_q;
  logic [TAG_W-1:0] a_tag_q, b_tag_q;

  logic a_hit, b_hit, own_hit;
  assign a_hit   = bus_v && !a_rdy_q && a_tag_q == bus_tag;
  assign b_hit   = bus_v && !b_rdy_q && b_tag_q == bus_tag;
  assign own_hit = bus_v && bus_tag == ID;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_FREE;
      a_rdy_q <= 1'b0;
      b_rdy_q <= 1'b0;
      a_tag_q <= '0;
      b_tag_q <= '0;
      op      <= '0;
      a_val   <= '0;
      b_val   <= '0;
    end else begin
      unique case (st_q)
        ST_FREE: if (alloc) begin
          st_q    <= ST_WAIT;
          op      <= in_op;
          a_rdy_q <= in_a_rdy;
          a_tag_q <= in_a_tag;
          a_val   <= in_a_val;
          b_rdy_q <= in_b_rdy;
          b_tag_q <= in_b_tag;
          b_val   <= in_b_val;
        end
        ST_WAIT: begin
          if (a_hit) begin
            a_rdy_q <= 1'b1;
            a_val   <= bus_val;
          end
          if (b_hit) begin
            b_rdy_q <= 1'b1;
            b_val   <= bus_val;
          end
          if (grant) st_q <= ST_EXEC;
        end
        ST_EXEC: if (own_hit) st_q <= ST_FREE;
        default: st_q <= ST_FREE;
      endcase
    end
  end

  assign busy  = st_q != ST_FREE;
  assign exec  = st_q == ST_EXEC;
  assign ready = st_q == ST_WAIT && a_rdy_q && b_rdy_q;

  // R1: the issue logic only allocates an idle station.
  assert_alloc_idle_R1: assert property (@(posedge clk) disable iff (rst)
    alloc |-> st_q == ST_FREE);
  // R7: the arbiter grants only a station with both operands present.
  assert_grant_ready_R7: assert property (@(posedge clk) disable iff (rst)
    grant |-> (st_q == ST_WAIT && a_rdy_q && b_rdy_q));
  // R9: a station becomes idle only when its own ID was broadcast.
  assert_free_on_bcast_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> $past(own_hit));
endmodule

// File: rtl/opsched_station_array.sv
module opsched_station_array #(
  parameter int NUM_ST  = 4,
  parameter int NUM_REG = 8,
  parameter int DATA_W  = 16,
  parameter int OP_W    = 2,
  localparam int TAG_W  = $clog2(NUM_ST + 1),
  localparam int RIW    = $clog2(NUM_REG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              iss_valid,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [RIW-1:0]    iss_srca,
  input  logic [RIW-1:0]    iss_srcb,
  input  logic [RIW-1:0]    iss_dst,
  output logic              iss_stall,
  output logic              disp_valid,
  output logic [OP_W-1:0]   disp_op,
  output logic [DATA_W-1:0] disp_opa,
  output logic [DATA_W-1:0] disp_opb,
  output logic [TAG_W-1:0]  disp_tag,
  input  logic              fu_valid,
  input  logic [TAG_W-1:0]  fu_tag,
  input  logic [DATA_W-1:0] fu_value,
  output logic              cdb_valid,
  output logic [TAG_W-1:0]  cdb_tag,
  output logic [DATA_W-1:0] cdb_value
);
  logic [NUM_ST-1:0] busy_v, exec_v, rdy_v, alloc_v, grant_v;
  logic [OP_W-1:0]   st_op [NUM_ST];
  logic [DATA_W-1:0] st_a  [NUM_ST];
  logic [DATA_W-1:0] st_b  [NUM_ST];

  // Issue side: lowest idle station takes the instruction.
  logic             iss_fire;
  logic [TAG_W-1:0] alloc_idx;
  always_comb begin
    alloc_idx = '0;
    for (int i = NUM_ST - 1; i >= 0; i--) if (!busy_v[i]) alloc_idx = TAG_W'(i);
  end
  assign iss_stall = &busy_v;
  assign iss_fire  = iss_valid && !iss_stall;
  for (genvar i = 0; i < NUM_ST; i++) begin : g_alloc
    assign alloc_v[i] = iss_fire && alloc_idx == TAG_W'(i);
  end

  // Register tag table lookup and source resolution with bus bypass (R3, R6).
  logic [TAG_W-1:0]  ta, tb;
  logic [DATA_W-1:0] va, vb;
  logic              a_rdy, b_rdy;
  logic [DATA_W-1:0] a_in, b_in;

  opsched_tag_table #(.NUM_REG(NUM_REG), .DATA_W(DATA_W), .TAG_W(TAG_W)) u_tags (
    .clk(clk), .rst(rst),
    .rd_a_idx(iss_srca), .rd_b_idx(iss_srcb),
    .rd_a_tag(ta), .rd_a_val(va), .rd_b_tag(tb), .rd_b_val(vb),
    .ren_en(iss_fire), .ren_idx(iss_dst), .ren_tag(alloc_idx + TAG_W'(1)),
    .bus_v(cdb_valid), .bus_tag(cdb_tag), .bus_val(cdb_value)
  );

  always_comb begin
    a_rdy = ta == '0 || (cdb_valid && cdb_tag == ta);
    b_rdy = tb == '0 || (cdb_valid && cdb_tag == tb);
    a_in  = ta == '0 ? va : cdb_value;
    b_in  = tb == '0 ? vb : cdb_value;
  end

  for (genvar i = 0; i < NUM_ST; i++) begin : g_st
    opsched_station #(
      .DATA_W(DATA_W), .TAG_W(TAG_W), .OP_W(OP_W), .ID(TAG_W'(i + 1))
    ) u_st (
      .clk(clk), .rst(rst), .alloc(alloc_v[i]), .in_op(iss_op),
      .in_a_rdy(a_rdy), .in_a_tag(ta), .in_a_val(a_in),
      .in_b_rdy(b_rdy), .in_b_tag(tb), .in_b_val(b_in),
      .bus_v(cdb_valid), .bus_tag(cdb_tag), .bus_val(cdb_value),
      .grant(grant_v[i]), .busy(busy_v[i]), .exec(exec_v[i]), .ready(rdy_v[i]),
      .op(st_op[i]), .a_val(st_a[i]), .b_val(st_b[i])
    );
  end

  // Dispatch: lowest-index ready station (R8).
  logic [TAG_W-1:0] disp_idx;
  logic             any_rdy;
  always_comb begin
    disp_idx = '0;
    for (int i = NUM_ST - 1; i >= 0; i--) if (rdy_v[i]) disp_idx = TAG_W'(i);
  end
  assign any_rdy = |rdy_v;
  for (genvar i = 0; i < NUM_ST; i++) begin : g_grant
    assign grant_v[i] = any_rdy && disp_idx == TAG_W'(i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      disp_valid <= 1'b0;
      disp_op    <= '0;
      disp_opa   <= '0;
      disp_opb   <= '0;
      disp_tag   <= '0;
      cdb_valid  <= 1'b0;
      cdb_tag    <= '0;
      cdb_value  <= '0;
    end else begin
      disp_valid <= any_rdy;
      if (any_rdy) begin
        disp_op  <= st_op[disp_idx];
        disp_opa <= st_a[disp_idx];
        disp_opb <= st_b[disp_idx];
        disp_tag <= disp_idx + TAG_W'(1);
      end
      cdb_valid <= fu_valid;
      cdb_tag   <= fu_tag;
      cdb_value <= fu_value;
    end
  end

  logic owner_exec;
  always_comb begin
    owner_exec = 1'b0;
    for (int i = 0; i < NUM_ST; i++) if (exec_v[i] && cdb_tag == TAG_W'(i + 1)) owner_exec = 1'b1;
  end

  // R9: the broadcast tag always belongs to a station that is executing.
  assert_bus_owner_R9: assert property (@(posedge clk) disable iff (rst)
    cdb_valid |-> owner_exec);
  // R8: at most one station is granted per cycle.
  assert_one_grant_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant_v));
  // R1: while every station is occupied none is allocated.
  assert_no_alloc_full_R1: assert property (@(posedge clk) disable iff (rst)
    iss_stall |-> alloc_v == '0);
endmodule

// File: tb/tb_opsched_station_array.sv
module tb_opsched_station_array;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int NS = 4;
  localparam int NR = 8;
  localparam int DW = 16;
  localparam int TW = 3;
  localparam int LAT = 3;

  logic clk = 0;
  logic rst = 1;
  always #4ns clk = ~clk;

  logic          iss_valid = 0;
  logic [1:0]    iss_op = 0;
  logic [2:0]    iss_srca = 0, iss_srcb = 0, iss_dst = 0;
  logic          iss_stall, disp_valid, cdb_valid;
  logic [1:0]    disp_op;
  logic [DW-1:0] disp_opa, disp_opb, cdb_value, fu_value;
  logic [TW-1:0] disp_tag, cdb_tag, fu_tag;
  logic          fu_valid;

  opsched_station_array #(.NUM_ST(NS), .NUM_REG(NR), .DATA_W(DW), .OP_W(2)) dut (
    .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_op(iss_op),
    .iss_srca(iss_srca), .iss_srcb(iss_srcb), .iss_dst(iss_dst), .iss_stall(iss_stall),
    .disp_valid(disp_valid), .disp_op(disp_op), .disp_opa(disp_opa), .disp_opb(disp_opb),
    .disp_tag(disp_tag), .fu_valid(fu_valid), .fu_tag(fu_tag), .fu_value(fu_value),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value)
  );

  function automatic int alu(input int op, input int a, input int b);
    case (op)
      0: return (a + b) & 16'hFFFF;
      1: return (a - b) & 16'hFFFF;
      2: return a ^ b;
      default: return a | b;
    endcase
  endfunction

  // Fixed-latency functional unit model.
  logic          pv [LAT];
  logic [TW-1:0] pt [LAT];
  logic [DW-1:0] pr [LAT];
  always @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < LAT; k++) pv[k] <= 1'b0;
    end else begin
      pv[0] <= disp_valid;
      pt[0] <= disp_tag;
      pr[0] <= DW'(alu(int'(disp_op), int'(disp_opa), int'(disp_opb)));
      for (int k = 1; k < LAT; k++) begin
        pv[k] <= pv[k-1];
        pt[k] <= pt[k-1];
        pr[k] <= pr[k-1];
      end
    end
  end
  assign fu_valid = pv[LAT-1];
  assign fu_tag   = pt[LAT-1];
  assign fu_value = pr[LAT-1];

  int n_chk = 0, n_fail = 0, n_bypass = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  // Reference model: sequential architectural values plus station bookkeeping.
  int arch [NR];
  int rtag [NR];
  bit m_busy [NS], m_exec [NS], m_ardy [NS], m_brdy [NS];
  int m_atag [NS], m_btag [NS], exp_a [NS], exp_b [NS], exp_r [NS], exp_op [NS];
  int prev_mask = 0;

  function automatic int lowest(input int m);
    for (int i = 0; i < NS; i++) if (m[i]) return i;
    return -1;
  endfunction

  function automatic bit any_busy();
    for (int i = 0; i < NS; i++) if (m_busy[i]) return 1;
    return 0;
  endfunction

  task automatic tick(input bit want, input int op, input int sa, input int sb, input int d,
                      output bit acc);
    int fm, mask_now, bt, s, ta, tb2;
    bit bus;
    @(negedge clk);
    fm = 0;
    for (int i = 0; i < NS; i++) if (!m_busy[i]) fm |= (1 << i);
    chk(iss_stall == (fm == 0), "R1 stall", int'(iss_stall), int'(fm == 0));
    if (disp_valid) begin
      s = int'(disp_tag) - 1;
      if (s < 0 || s >= NS) chk(0, "R2 dispatch tag", int'(disp_tag), 1);
      else begin
        chk(lowest(prev_mask) == s, "R8 lowest ready first", s, lowest(prev_mask));
        chk(int'(disp_opa) == exp_a[s], "R3/R5 operand A", int'(disp_opa), exp_a[s]);
        chk(int'(disp_opb) == exp_b[s], "R3/R5 operand B", int'(disp_opb), exp_b[s]);
        chk(int'(disp_op) == exp_op[s], "R7 opcode", int'(disp_op), exp_op[s]);
        m_exec[s] = 1;
      end
    end else begin
      chk(prev_mask == 0, "R7 ready station not dispatched", 0, prev_mask);
    end
    mask_now = 0;
    for (int i = 0; i < NS; i++)
      if (m_busy[i] && !m_exec[i] && m_ardy[i] && m_brdy[i]) mask_now |= (1 << i);
    bus = cdb_valid;
    bt  = int'(cdb_tag);
    if (bus) begin
      if (bt < 1 || bt > NS) chk(0, "R9 bus tag", bt, 1);
      else begin
        chk(int'(cdb_value) == exp_r[bt-1], "R9 broadcast value", int'(cdb_value), exp_r[bt-1]);
        chk(m_exec[bt-1], "R9 broadcast owner executing", int'(m_exec[bt-1]), 1);
      end
    end
    acc = want && fm != 0;
    s = lowest(fm);
    ta = acc ? rtag[sa] : 0;
    tb2 = acc ? rtag[sb] : 0;
    if (acc && bus && ((ta != 0 && ta == bt) || (tb2 != 0 && tb2 == bt))) n_bypass++;
    // Apply broadcast (R5, R9, R10).
    if (bus && bt >= 1 && bt <= NS) begin
      for (int i = 0; i < NS; i++) begin
        if (m_busy[i] && !m_ardy[i] && m_atag[i] == bt) m_ardy[i] = 1;
        if (m_busy[i] && !m_brdy[i] && m_btag[i] == bt) m_brdy[i] = 1;
      end
      for (int r = 0; r < NR; r++) if (rtag[r] == bt) rtag[r] = 0;
      m_busy[bt-1] = 0;
      m_exec[bt-1] = 0;
    end
    // Apply issue (R3, R4, R6).
    if (acc) begin
      m_busy[s] = 1;
      m_exec[s] = 0;
      m_ardy[s] = (ta == 0) || (bus && ta == bt);
      m_brdy[s] = (tb2 == 0) || (bus && tb2 == bt);
      m_atag[s] = ta;
      m_btag[s] = tb2;
      exp_a[s]  = arch[sa];
      exp_b[s]  = arch[sb];
      exp_op[s] = op;
      exp_r[s]  = alu(op, arch[sa], arch[sb]);
      arch[d]   = exp_r[s];
      rtag[d]   = s + 1;
    end
    prev_mask = mask_now;
    iss_valid = want;
    if (acc) begin
      iss_op = 2'(op); iss_srca = 3'(sa); iss_srcb = 3'(sb); iss_dst = 3'(d);
    end else begin
      iss_op = 2'(op ^ 1); iss_srca = 3'(sa ^ 3); iss_srcb = 3'(sb ^ 5); iss_dst = 3'(d ^ 6);
    end
  endtask

  task automatic issue(input int op, input int sa, input int sb, input int d);
    bit acc;
    int guard = 0;
    do begin
      tick(1, op, sa, sb, d, acc);
      guard++;
    end while (!acc && guard < 1000);
  endtask

  task automatic drain();
    bit acc;
    for (int k = 0; k < 400 && any_busy(); k++) tick(0, 0, 0, 0, 0, acc);
    for (int k = 0; k < LAT + 3; k++) tick(0, 0, 0, 0, 0, acc);
  endtask

  initial begin
    #1_200_000ns;
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    bit acc;
    for (int r = 0; r < NR; r++) begin
      arch[r] = r;
      rtag[r] = 0;
    end
    for (int i = 0; i < NS; i++) begin
      m_busy[i] = 0; m_exec[i] = 0; m_ardy[i] = 0; m_brdy[i] = 0;
      m_atag[i] = 0; m_btag[i] = 0;
    end
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R11: idle after reset.
    chk(iss_stall == 0, "R11 reset stall", int'(iss_stall), 0);
    chk(disp_valid == 0, "R11 reset dispatch", int'(disp_valid), 0);
    chk(cdb_valid == 0, "R11 reset bus", int'(cdb_valid), 0);
    // R11: reading every register first exposes the reset values r.
    for (int r = 0; r < NR; r++) issue(0, r, r, r);
    drain();
    // Sweep every (dst, srcA, srcB) combination back to back: renaming, overwritten
    // tags (R4, R10), bus capture (R5), bypass (R6), stalls (R1), ordering (R8).
    for (int d = 0; d < NR; d++)
      for (int a = 0; a < NR; a++)
        for (int b = 0; b < NR; b++)
          issue((a + b + d) % 4, a, b, d);
    drain();
    // Dependency chains on two registers: several stations wake on one broadcast (R8).
    for (int n = 0; n < 64; n++) issue(n % 4, n % 2, (n + 1) % 2, (n / 3) % 2);
    drain();
    // Final readout of all registers against the sequential model.
    for (int r = 0; r < NR; r++) issue(2, r, r, r);
    drain();
    chk(n_bypass > 0, "R6 same-cycle bypass exercised", n_bypass, 1);
    chk(!any_busy() && iss_stall == 0, "R9 all stations freed", int'(iss_stall), 0);
    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule